// File: doc/BRIEF.md
# Programmable DRAM Auto-Refresh Timer

This block produces the periodic refresh requests a DDR-SDRAM controller needs. Software programs it through a one-cycle configuration write that carries an on/off bit and a 3-bit period selector. A down-counter measures each refresh period. When the counter expires, the block raises `refresh_req`. The request stays high until the command sequencer acknowledges it. The next period starts counting at the moment of expiry, so the refresh cadence does not drift while a request waits for its acknowledge.

The block defines exactly when a new period setting takes effect. When refresh is switched on, the first period is timed from the selector value held in the mode register just before that write. If the same write also carries a new selector, that new value governs only the second and later periods. A selector programmed while refresh is off is already in force for the first period once refresh is switched on. The status output `active_sel` shows which selector is timing the period in progress.

The request pair follows a valid/ready discipline. `refresh_req` is the valid signal and `refresh_ack` is the ready signal, and a request completes in a cycle where both are high. The requester never withdraws a request on its own. The only exception is switching refresh off, which drops a pending request at once.

Top module: `refresh_sched`

## Requirements
- R1: After synchronous reset, `refresh_req` is 0 and `active_sel` is 0. Refresh is off and the stored selector is 0.
- R2: The period for selector value s is BASE_CYC << s cycles (BASE_CYC = 8 by default). The first rising edge of `refresh_req` comes exactly one period after the clock edge that captures the enabling write. Later rising edges follow at the same spacing.
- R3: If an enabling write (`cfg_we`=1, `cfg_en`=1, refresh previously off) also carries a new `cfg_sel`, the first period uses the selector that was stored before that write. `active_sel` shows that old value during the first period.
- R4: Every period after the first uses the selector stored at the moment the previous period expires. `active_sel` switches to that value at the expiry edge.
- R5: Once raised, `refresh_req` stays high until a clock edge where `refresh_ack` is 1. It is low after that edge, unless a new expiry falls on the same edge.
- R6: The counter keeps running while a request is pending. Expiries stay exactly one period apart, whatever the acknowledge latency.
- R7: If an expiry and an acknowledge fall on the same clock edge, `refresh_req` stays high after that edge.
- R8: A write with `cfg_en`=0 stops the counter and drops `refresh_req` at that edge without an acknowledge. No request rises while refresh is off.
- R9: A selector written while refresh is on does not change the period in progress, and `active_sel` holds until the next expiry.
- R10: An acknowledge while no request is pending has no effect: `refresh_req` stays 0 and the next expiry time is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_en | input | 1 | Refresh on (1) or off (0), captured when cfg_we is 1 |
| cfg_sel | input | SEL_W | Period selector, captured when cfg_we is 1 |
| refresh_req | output | 1 | Refresh request (valid) |
| refresh_ack | input | 1 | Request accepted by the sequencer (ready) |
| active_sel | output | SEL_W | Selector timing the period in progress |

## Verification
Two events can land on the same clock edge: a counter expiry that raises a new request, and the acknowledge that retires the previous one. The bench holds back the acknowledge so that a request stays pending. It then drives `refresh_ack` in the cycle just before the next expiry edge. Afterwards it checks that `refresh_req` is still high and that the following rising edges come exactly one period apart. A second overlap occurs when the enabling write carries a new selector. The scoreboard judges this case by the timing of the first request and the value of `active_sel` in each period.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  // Cycle count of one refresh period for a given selector value.
  function automatic int unsigned period_of(input int unsigned base, input int unsigned sel);
    return base << sel;
  endfunction
endpackage

// File: rtl/rs_mode_reg.sv
module rs_mode_reg #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic [SEL_W-1:0] cfg_sel,
  output logic             en_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             start,
  output logic             stop
);
  // The start pulse fires on the write that turns refresh on. The timer loads
  // from sel_q, which still holds the selector from before this write.
  assign start = cfg_we && cfg_en && !en_q;
  assign stop  = cfg_we && !cfg_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      sel_q <= '0;
    end else if (cfg_we) begin
      en_q  <= cfg_en;
      sel_q <= cfg_sel;
    end
  end
endmodule

// File: rtl/rs_interval_lut.sv
module rs_interval_lut #(
  parameter int SEL_W    = 3,
  parameter int BASE_CYC = 8,
  parameter int CNT_W    = 10
) (
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] reload
);
  import refresh_pkg::*;
  localparam int N_SEL = 2 ** SEL_W;

  logic [CNT_W-1:0] tbl [N_SEL];

  // Each entry holds period - 1, because the counter counts down to zero inclusive.
  for (genvar i = 0; i < N_SEL; i++) begin : g_entry
    assign tbl[i] = CNT_W'(period_of(BASE_CYC, i) - 1);
  end

  assign reload = tbl[sel];
endmodule

// File: rtl/rs_period_timer.sv
module rs_period_timer #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_q,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] reload,
  input  logic [SEL_W-1:0] sel_q,
  output logic             expire,
  output logic [SEL_W-1:0] active_sel
);
  logic [CNT_W-1:0] cnt;
  logic             run;

  // A disabling write freezes the counter on the same edge.
  assign run    = en_q && !stop;
  assign expire = run && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      active_sel <= '0;
    end else if (start || expire) begin
      // Both the first load and every reload read the stored selector.
      cnt        <= reload;
      active_sel <= sel_q;
    end else if (run) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rs_req_hold.sv
module rs_req_hold (
  input  logic clk,
  input  logic rst,
  input  logic stop,
  input  logic expire,
  input  logic ack,
  output logic req
);
  // Priority, highest first: disable, then new expiry, then acknowledge.
  always_ff @(posedge clk) begin
    if (rst)         req <= 1'b0;
    else if (stop)   req <= 1'b0;
    else if (expire) req <= 1'b1;
    else if (ack)    req <= 1'b0;
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int SEL_W    = 3,
  parameter int BASE_CYC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_en,
  input  logic [SEL_W-1:0] cfg_sel,
  output logic             refresh_req,
  input  logic             refresh_ack,
  output logic [SEL_W-1:0] active_sel
);
  localparam int MAX_PERIOD = BASE_CYC << (2 ** SEL_W - 1);
  localparam int CNT_W      = $clog2(MAX_PERIOD);

  logic             mode_en;
  logic [SEL_W-1:0] mode_sel;
  logic             mode_start;
  logic             mode_stop;
  logic [CNT_W-1:0] lut_reload;
  logic             tmr_expire;

  rs_mode_reg #(.SEL_W(SEL_W)) u_mode (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_sel(cfg_sel),
    .en_q(mode_en), .sel_q(mode_sel), .start(mode_start), .stop(mode_stop)
  );

  rs_interval_lut #(.SEL_W(SEL_W), .BASE_CYC(BASE_CYC), .CNT_W(CNT_W)) u_lut (
    .sel(mode_sel), .reload(lut_reload)
  );

  rs_period_timer #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .en_q(mode_en), .start(mode_start), .stop(mode_stop),
    .reload(lut_reload), .sel_q(mode_sel), .expire(tmr_expire), .active_sel(active_sel)
  );

  rs_req_hold u_req (
    .clk(clk), .rst(rst), .stop(mode_stop), .expire(tmr_expire),
    .ack(refresh_ack), .req(refresh_req)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic             cfg_en,
  input logic             refresh_req,
  input logic             refresh_ack,
  input logic             expire,
  input logic             start,
  input logic [SEL_W-1:0] active_sel
);
  assert_drop_on_disable_R8: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && !cfg_en) |=> !refresh_req);

  assert_hold_pending_R5: assert property (@(posedge clk) disable iff (rst)
    (refresh_req && !refresh_ack && !(cfg_we && !cfg_en)) |=> refresh_req);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (refresh_req && refresh_ack && !expire) |=> !refresh_req);

  assert_overlap_keeps_R7: assert property (@(posedge clk) disable iff (rst)
    (expire && refresh_ack) |=> refresh_req);

  assert_rise_from_expiry_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(refresh_req) |-> $past(expire));

  assert_status_held_R9: assert property (@(posedge clk) disable iff (rst)
    (!expire && !start) |=> $stable(active_sel));
endmodule

bind refresh_sched refresh_sched_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_en(cfg_en),
  .refresh_req(refresh_req), .refresh_ack(refresh_ack),
  .expire(tmr_expire), .start(mode_start), .active_sel(active_sel)
);

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
  localparam int SEL_W = 3;
  localparam int BASE  = 8;

  typedef struct {
    int    t;
    int    sel;
    string tag;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic             cfg_en = 1'b0;
  logic [SEL_W-1:0] cfg_sel = '0;
  logic             refresh_req;
  logic             auto_ack = 1'b0;
  logic             man_ack = 1'b0;
  logic             refresh_ack;
  logic [SEL_W-1:0] active_sel;

  int   cyc = 0;
  int   total = 0;
  int   bad = 0;
  bit   auto_en = 1'b0;
  bit   prev_req = 1'b0;
  exp_t sb[$];

  assign refresh_ack = auto_ack | man_ack;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  refresh_sched #(.SEL_W(SEL_W), .BASE_CYC(BASE)) u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_en(cfg_en), .cfg_sel(cfg_sel),
    .refresh_req(refresh_req), .refresh_ack(refresh_ack), .active_sel(active_sel)
  );

  function automatic int per(input int s);
    return BASE << s;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Called at a negedge; returns the edge number that captures the write.
  task automatic wr(input bit en, input int sel, output int edge_no);
    cfg_we  = 1'b1;
    cfg_en  = en;
    cfg_sel = SEL_W'(sel);
    edge_no = cyc + 1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic push(input int t, input int sel, input string tag);
    exp_t e;
    e.t = t; e.sel = sel; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: pops the scoreboard on each rising request; auto-acks when enabled.
  always @(negedge clk) begin
    if (!rst) begin
      if (auto_ack) begin
        auto_ack <= 1'b0;
        chk(refresh_req == 1'b0, "R5 ack clears", int'(refresh_req), 0);
      end
      if (refresh_req && !prev_req) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8/R10 unexpected request", cyc, -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc == e.t, {e.tag, " request time"}, cyc, e.t);
          chk(int'(active_sel) == e.sel, {e.tag, " active_sel"}, int'(active_sel), e.sel);
        end
        if (auto_en) auto_ack <= 1'b1;
      end
      prev_req <= refresh_req;
    end
  end

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t0;
    int d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(refresh_req == 1'b0, "R1 req", int'(refresh_req), 0);
    chk(active_sel == '0, "R1 active_sel", int'(active_sel), 0);

    // R2: selector programmed while off, then enabled
    auto_en = 1'b1;
    wr(1'b0, 1, d);
    wr(1'b1, 1, t0);
    push(t0 + per(1), 1, "R2");
    push(t0 + 2 * per(1), 1, "R2");
    push(t0 + 3 * per(1), 1, "R2");
    wait_until(t0 + 3 * per(1) + 2);

    // R8: disable, then a long quiet stretch
    wr(1'b0, 1, d);
    chk(refresh_req == 1'b0, "R8 off", int'(refresh_req), 0);
    wait_until(d + 100);
    chk(refresh_req == 1'b0, "R8 stays off", int'(refresh_req), 0);

    // R3/R4: enable with a new selector in the same write (old = 1, new = 2)
    wr(1'b1, 2, t0);
    push(t0 + 16, 2, "R3");
    push(t0 + 48, 2, "R4");
    push(t0 + 80, 0, "R9");
    push(t0 + 88, 0, "R9");
    push(t0 + 96, 0, "R9");
    wait_until(t0 + 5);
    chk(active_sel == 3'd1, "R3 old sel in first period", int'(active_sel), 1);
    wait_until(t0 + 20);
    chk(active_sel == 3'd2, "R4 new sel later", int'(active_sel), 2);
    // R9: rewrite while on, mid-period
    wait_until(t0 + 60);
    wr(1'b1, 0, d);
    chk(active_sel == 3'd2, "R9 status held", int'(active_sel), 2);
    wait_until(t0 + 99);
    wr(1'b0, 0, d);

    // R6/R7/R10: manual acknowledge, selector 0 (period 8)
    auto_en = 1'b0;
    wait_until(d + 5);
    wr(1'b1, 0, t0);
    push(t0 + 8, 0, "R6");
    push(t0 + 16, 0, "R6");
    push(t0 + 32, 0, "R6");
    wait_until(t0 + 11);
    man_ack = 1'b1;
    @(negedge clk);
    man_ack = 1'b0;
    chk(refresh_req == 1'b0, "R5 late ack", int'(refresh_req), 0);
    wait_until(t0 + 23);
    man_ack = 1'b1;          // lands on expiry edge t0+24
    @(negedge clk);
    chk(refresh_req == 1'b1, "R7 overlap keeps req", int'(refresh_req), 1);
    @(negedge clk);          // ack held over edge t0+25
    man_ack = 1'b0;
    chk(refresh_req == 1'b0, "R5 ack after overlap", int'(refresh_req), 0);
    wait_until(t0 + 27);
    man_ack = 1'b1;          // idle ack at edge t0+28
    @(negedge clk);
    man_ack = 1'b0;
    chk(refresh_req == 1'b0, "R10 idle ack", int'(refresh_req), 0);
    chk(active_sel == 3'd0, "R10 status", int'(active_sel), 0);
    wait_until(t0 + 33);
    chk(refresh_req == 1'b1, "R6 pending", int'(refresh_req), 1);
    wr(1'b0, 0, d);          // drop pending request without ack
    chk(refresh_req == 1'b0, "R8 drop pending", int'(refresh_req), 0);
    wait_until(d + 60);

    chk(sb.size() == 0, "R2 all expected requests seen", sb.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule